// File: doc/BRIEF.md
# Host Request Mailbox Bridge

This block stands between an external host and an embedded processor. It takes the place of a memory-mapped target on the host's AXI4-Lite bus, but it has no storage behind that bus. It latches each host read address, write address and write data into holding registers. The host's transaction then stays open. An interrupt tells firmware that work is waiting, and firmware handles the access through a second AXI4-Lite port that holds a small register window.

For a host read, firmware fetches the held address and writes the reply word, and the block returns that word on the host R channel. For a host write, firmware fetches the held address and data, then writes a trigger that issues the host B response. The block accepts one read and one write at a time. Completion flags let firmware poll until the host has taken each response.

Top module: `hostmbx_bridge`

## Requirements
- R1: After reset, host ARREADY, AWREADY and WREADY are high, and RVALID, BVALID and irq are low. Every firmware register reads as zero.
- R2: A host AR handshake stores the address and drops ARREADY until the R handshake. Firmware offset 0x4 reads {stored address bits [DW-1:1], 1} while the read is held. Control bit 8 is set for the same period.
- R3: While a read is held and no R response is outstanding, a firmware write to offset 0xC raises host RVALID with that word as RDATA and RRESP=0. RVALID and RDATA stay unchanged until RREADY. The write has no effect when no read is held.
- R4: The R handshake clears control bit 8 and the valid bit of offset 0x4, sets control bit 10 and raises ARREADY again. The next AR capture clears bit 10.
- R5: The host AW and W channels are captured independently. Each ready drops after its own handshake and stays low until the B handshake. Control bit 9 marks a held address and bit 11 marks held data. Offset 0x8 reads {address bits [DW-1:1], bit 9}, and offset 0x10 reads the held data.
- R6: A firmware write to offset 0x14 with bit 0 set raises host BVALID with BRESP=0, provided both address and data are held and no B response is outstanding. BVALID stays high until BREADY. Otherwise the write has no effect.
- R7: The B handshake clears bits 9 and 11, sets control bit 12 and raises AWREADY and WREADY. The next AW capture clears bit 12.
- R8: Control bits 0 and 1 are read/write interrupt enables. irq equals (bit0 AND bit8) OR (bit1 AND bit9 AND bit11), so writing zero to offset 0x0 lowers irq.
- R9: Firmware writes to offsets 0x4, 0x8 and 0x10 change nothing. Reads of 0xC, 0x14 and any unlisted offset return zero.
- R10: The firmware port accepts a write when AWVALID and WVALID are both high and no B response is outstanding, and returns B with BRESP=0 on the next cycle. It accepts a read when no R response is outstanding, and returns R with RRESP=0 on the next cycle. The returned word shows the register state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_awaddr | input | DW | Host write address |
| h_awvalid | input | 1 | Host write address valid |
| h_awready | output | 1 | Host write address ready |
| h_wdata | input | DW | Host write data |
| h_wvalid | input | 1 | Host write data valid |
| h_wready | output | 1 | Host write data ready |
| h_bresp | output | 2 | Host write response (always 0) |
| h_bvalid | output | 1 | Host write response valid |
| h_bready | input | 1 | Host write response ready |
| h_araddr | input | DW | Host read address |
| h_arvalid | input | 1 | Host read address valid |
| h_arready | output | 1 | Host read address ready |
| h_rdata | output | DW | Host read data |
| h_rresp | output | 2 | Host read response (always 0) |
| h_rvalid | output | 1 | Host read data valid |
| h_rready | input | 1 | Host read data ready |
| fw_awaddr | input | FW_AW | Firmware write offset |
| fw_awvalid | input | 1 | Firmware write address valid |
| fw_awready | output | 1 | Firmware write address ready |
| fw_wdata | input | DW | Firmware write data |
| fw_wvalid | input | 1 | Firmware write data valid |
| fw_wready | output | 1 | Firmware write data ready |
| fw_bresp | output | 2 | Firmware write response (always 0) |
| fw_bvalid | output | 1 | Firmware write response valid |
| fw_bready | input | 1 | Firmware write response ready |
| fw_araddr | input | FW_AW | Firmware read offset |
| fw_arvalid | input | 1 | Firmware read address valid |
| fw_arready | output | 1 | Firmware read address ready |
| fw_rdata | output | DW | Firmware read data |
| fw_rresp | output | 2 | Firmware read response (always 0) |
| fw_rvalid | output | 1 | Firmware read data valid |
| fw_rready | input | 1 | Firmware read data ready |
| irq | output | 1 | Interrupt to the processor |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the host R and B handshakes, which update the two completion flags together. The second pair is a firmware read of the control word and a host AR capture, where the read must return the pre-capture state. The bench holds RREADY and BREADY low while both responses are armed, then raises them on the same edge. It also forks a firmware control read against a host read address. A behavioural model, updated on every edge, judges each outcome, and every output is compared against it once per cycle.

// File: rtl/hostmbx_bridge.sv
module hostmbx_bridge #(
  parameter int DW    = 32,
  parameter int FW_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    h_awaddr,
  input  logic             h_awvalid,
  output logic             h_awready,
  input  logic [DW-1:0]    h_wdata,
  input  logic             h_wvalid,
  output logic             h_wready,
  output logic [1:0]       h_bresp,
  output logic             h_bvalid,
  input  logic             h_bready,
  input  logic [DW-1:0]    h_araddr,
  input  logic             h_arvalid,
  output logic             h_arready,
  output logic [DW-1:0]    h_rdata,
  output logic [1:0]       h_rresp,
  output logic             h_rvalid,
  input  logic             h_rready,
  input  logic [FW_AW-1:0] fw_awaddr,
  input  logic             fw_awvalid,
  output logic             fw_awready,
  input  logic [DW-1:0]    fw_wdata,
  input  logic             fw_wvalid,
  output logic             fw_wready,
  output logic [1:0]       fw_bresp,
  output logic             fw_bvalid,
  input  logic             fw_bready,
  input  logic [FW_AW-1:0] fw_araddr,
  input  logic             fw_arvalid,
  output logic             fw_arready,
  output logic [DW-1:0]    fw_rdata,
  output logic [1:0]       fw_rresp,
  output logic             fw_rvalid,
  input  logic             fw_rready,
  output logic             irq
);
  localparam logic [FW_AW-1:0] OFS_CTRL  = FW_AW'(8'h00);
  localparam logic [FW_AW-1:0] OFS_RADDR = FW_AW'(8'h04);
  localparam logic [FW_AW-1:0] OFS_WADDR = FW_AW'(8'h08);
  localparam logic [FW_AW-1:0] OFS_RDATA = FW_AW'(8'h0C);
  localparam logic [FW_AW-1:0] OFS_WDATA = FW_AW'(8'h10);
  localparam logic [FW_AW-1:0] OFS_BGO   = FW_AW'(8'h14);

  logic          ie_rd, ie_wr;
  logic          rd_pend, rd_done, aw_pend, w_pend, wr_done;
  logic [DW-1:0] rd_addr, wr_addr, wr_data, rsp_data;
  logic          rsp_rvalid, rsp_bvalid, f_bvalid, f_rvalid;
  logic [DW-1:0] f_rdata, rd_mux, ctrl_word;

  wire ar_hs = h_arvalid && !rd_pend;
  wire r_hs  = rsp_rvalid && h_rready;
  wire aw_hs = h_awvalid && !aw_pend;
  wire w_hs  = h_wvalid && !w_pend;
  wire b_hs  = rsp_bvalid && h_bready;
  wire fw_wr = fw_awvalid && fw_wvalid && !f_bvalid;
  wire fw_rd = fw_arvalid && !f_rvalid;

  assign h_arready  = !rd_pend;
  assign h_awready  = !aw_pend;
  assign h_wready   = !w_pend;
  assign h_rvalid   = rsp_rvalid;
  assign h_rdata    = rsp_data;
  assign h_bvalid   = rsp_bvalid;
  assign h_rresp    = 2'b00;
  assign h_bresp    = 2'b00;
  assign fw_awready = fw_wr;
  assign fw_wready  = fw_wr;
  assign fw_bvalid  = f_bvalid;
  assign fw_bresp   = 2'b00;
  assign fw_arready = !f_rvalid;
  assign fw_rvalid  = f_rvalid;
  assign fw_rdata   = f_rdata;
  assign fw_rresp   = 2'b00;
  assign irq = (ie_rd && rd_pend) || (ie_wr && aw_pend && w_pend);

  always_comb begin
    ctrl_word     = '0;
    ctrl_word[0]  = ie_rd;
    ctrl_word[1]  = ie_wr;
    ctrl_word[8]  = rd_pend;
    ctrl_word[9]  = aw_pend;
    ctrl_word[10] = rd_done;
    ctrl_word[11] = w_pend;
    ctrl_word[12] = wr_done;
  end

  always_comb begin
    case (fw_araddr)
      OFS_CTRL:  rd_mux = ctrl_word;
      OFS_RADDR: rd_mux = {rd_addr[DW-1:1], rd_pend};
      OFS_WADDR: rd_mux = {wr_addr[DW-1:1], aw_pend};
      OFS_WDATA: rd_mux = wr_data;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_rd <= 1'b0;  ie_wr <= 1'b0;
      rd_pend <= 1'b0; rd_done <= 1'b0; rsp_rvalid <= 1'b0;
      aw_pend <= 1'b0; w_pend <= 1'b0; wr_done <= 1'b0; rsp_bvalid <= 1'b0;
      rd_addr <= '0; wr_addr <= '0; wr_data <= '0; rsp_data <= '0;
      f_bvalid <= 1'b0; f_rvalid <= 1'b0; f_rdata <= '0;
    end else begin
      if (ar_hs) begin
        rd_addr <= h_araddr;
        rd_pend <= 1'b1;
        rd_done <= 1'b0;
      end else if (r_hs) begin
        rd_pend    <= 1'b0;
        rsp_rvalid <= 1'b0;
        rd_done    <= 1'b1;
      end
      if (fw_wr && fw_awaddr == OFS_RDATA && rd_pend && !rsp_rvalid) begin
        rsp_data   <= fw_wdata;
        rsp_rvalid <= 1'b1;
      end

      if (aw_hs) begin
        wr_addr <= h_awaddr;
        aw_pend <= 1'b1;
        wr_done <= 1'b0;
      end
      if (w_hs) begin
        wr_data <= h_wdata;
        w_pend  <= 1'b1;
      end
      if (b_hs) begin
        aw_pend    <= 1'b0;
        w_pend     <= 1'b0;
        rsp_bvalid <= 1'b0;
        wr_done    <= 1'b1;
      end
      if (fw_wr && fw_awaddr == OFS_BGO && fw_wdata[0] && aw_pend && w_pend && !rsp_bvalid)
        rsp_bvalid <= 1'b1;

      if (fw_wr && fw_awaddr == OFS_CTRL) begin
        ie_rd <= fw_wdata[0];
        ie_wr <= fw_wdata[1];
      end

      if (fw_wr) f_bvalid <= 1'b1;
      else if (fw_bready) f_bvalid <= 1'b0;
      if (fw_rd) begin
        f_rvalid <= 1'b1;
        f_rdata  <= rd_mux;
      end else if (fw_rready) f_rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/hostmbx_bridge_chk.sv
module hostmbx_bridge_chk #(
  parameter int DW    = 32,
  parameter int FW_AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_awvalid,
  input logic          h_awready,
  input logic          h_wready,
  input logic [1:0]    h_bresp,
  input logic          h_bvalid,
  input logic          h_bready,
  input logic          h_arvalid,
  input logic          h_arready,
  input logic [DW-1:0] h_rdata,
  input logic [1:0]    h_rresp,
  input logic          h_rvalid,
  input logic          h_rready,
  input logic          fw_awready,
  input logic          fw_bvalid,
  input logic          irq
);
  AST_AR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    h_arvalid && h_arready |=> !h_arready); // R2
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid && !h_rready |=> h_rvalid && $stable(h_rdata)); // R3
  AST_R_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> h_rresp == 2'b00); // R3
  AST_AR_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid && h_rready |=> h_arready); // R4
  AST_AW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    h_awvalid && h_awready |=> !h_awready); // R5
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    h_bvalid && !h_bready |=> h_bvalid); // R6
  AST_B_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    h_bvalid |-> h_bresp == 2'b00); // R6
  AST_B_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    h_bvalid && h_bready |=> h_awready && h_wready); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    h_arready && h_awready |-> !irq); // R8
  AST_FW_BRESP: assert property (@(posedge clk) disable iff (!rst_n)
    fw_awready |=> fw_bvalid); // R10
endmodule

bind hostmbx_bridge hostmbx_bridge_chk #(.DW(DW), .FW_AW(FW_AW)) chk_i (.*);

// File: tb/hostmbx_bridge_tb_top.sv
`timescale 1ns/1ps
module hostmbx_bridge_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] h_awaddr = '0, h_wdata = '0, h_araddr = '0, fw_wdata = '0;
  logic h_awvalid = 0, h_wvalid = 0, h_bready = 1, h_arvalid = 0, h_rready = 1;
  logic [7:0] fw_awaddr = '0, fw_araddr = '0;
  logic fw_awvalid = 0, fw_wvalid = 0, fw_bready = 1, fw_arvalid = 0, fw_rready = 1;
  logic h_awready, h_wready, h_bvalid, h_arready, h_rvalid, irq;
  logic fw_awready, fw_wready, fw_bvalid, fw_arready, fw_rvalid;
  logic [1:0] h_bresp, h_rresp, fw_bresp, fw_rresp;
  logic [31:0] h_rdata, fw_rdata;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  hostmbx_bridge dut_i (.*);

  // behavioural reference
  bit m_ier, m_iew, m_rp, m_rd, m_rv, m_awp, m_wp, m_wd, m_bv, m_fbv, m_frv;
  logic [31:0] m_ra = 0, m_wa = 0, m_wdat = 0, m_rdat = 0, m_frd = 0;

  function automatic logic [31:0] regval(input logic [7:0] a);
    case (a)
      8'h00: return {19'd0, m_wd, m_wp, m_rd, m_awp, m_rp, 6'd0, m_iew, m_ier};
      8'h04: return {m_ra[31:1], m_rp};
      8'h08: return {m_wa[31:1], m_awp};
      8'h10: return m_wdat;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ier, m_iew, m_rp, m_rd, m_rv, m_awp, m_wp, m_wd, m_bv, m_fbv, m_frv} = '0;
      m_ra = 0; m_wa = 0; m_wdat = 0; m_rdat = 0; m_frd = 0;
    end else begin
      bit ar, r, aw, w, b, fw, fr, rp0, awp0, wp0, rv0, bv0;
      logic [31:0] rv_word;
      ar = h_arvalid && !m_rp;   r = m_rv && h_rready;
      aw = h_awvalid && !m_awp;  w = h_wvalid && !m_wp;
      b = m_bv && h_bready;
      fw = fw_awvalid && fw_wvalid && !m_fbv;
      fr = fw_arvalid && !m_frv;
      rv_word = regval(fw_araddr);
      rp0 = m_rp; awp0 = m_awp; wp0 = m_wp; rv0 = m_rv; bv0 = m_bv;
      if (ar) begin m_ra = h_araddr; m_rp = 1; m_rd = 0; end
      if (r)  begin m_rp = 0; m_rv = 0; m_rd = 1; end
      if (fw && fw_awaddr == 8'h0C && rp0 && !rv0) begin m_rdat = fw_wdata; m_rv = 1; end
      if (aw) begin m_wa = h_awaddr; m_awp = 1; m_wd = 0; end
      if (w)  begin m_wdat = h_wdata; m_wp = 1; end
      if (b)  begin m_awp = 0; m_wp = 0; m_bv = 0; m_wd = 1; end
      if (fw && fw_awaddr == 8'h14 && fw_wdata[0] && awp0 && wp0 && !bv0) m_bv = 1;
      if (fw && fw_awaddr == 8'h00) begin m_ier = fw_wdata[0]; m_iew = fw_wdata[1]; end
      if (fw) m_fbv = 1; else if (fw_bready) m_fbv = 0;
      if (fr) begin m_frv = 1; m_frd = rv_word; end else if (fw_rready) m_frv = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1.5;
    check("R2 h_arready", h_arready, !m_rp);
    check("R5 h_awready", h_awready, !m_awp);
    check("R5 h_wready", h_wready, !m_wp);
    check("R3 h_rvalid", h_rvalid, m_rv);
    if (m_rv) begin
      check("R3 h_rdata", h_rdata, m_rdat);
      check("R3 h_rresp", h_rresp, 0);
    end
    check("R6 h_bvalid", h_bvalid, m_bv);
    if (m_bv) check("R6 h_bresp", h_bresp, 0);
    check("R8 irq", irq, (m_ier && m_rp) || (m_iew && m_awp && m_wp));
    check("R10 fw_awready", fw_awready, fw_awvalid && fw_wvalid && !m_fbv);
    check("R10 fw_bvalid", fw_bvalid, m_fbv);
    check("R10 fw_rvalid", fw_rvalid, m_frv);
    if (m_frv) check("fw_rdata R4 R7 R9", fw_rdata, m_frd);
  end

  task automatic fw_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    fw_awaddr = a; fw_wdata = d; fw_awvalid = 1; fw_wvalid = 1;
    @(negedge clk);
    fw_awvalid = 0; fw_wvalid = 0;
    @(negedge clk);
  endtask

  task automatic fw_read(input logic [7:0] a);
    @(negedge clk);
    fw_araddr = a; fw_arvalid = 1;
    @(negedge clk);
    fw_arvalid = 0;
    @(negedge clk);
  endtask

  task automatic host_ar(input logic [31:0] a);
    @(negedge clk);
    h_araddr = a; h_arvalid = 1;
    while (!h_arready) @(negedge clk);
    @(negedge clk);
    h_arvalid = 0;
  endtask

  task automatic host_aw(input logic [31:0] a);
    @(negedge clk);
    h_awaddr = a; h_awvalid = 1;
    while (!h_awready) @(negedge clk);
    @(negedge clk);
    h_awvalid = 0;
  endtask

  task automatic host_w(input logic [31:0] d);
    @(negedge clk);
    h_wdata = d; h_wvalid = 1;
    while (!h_wready) @(negedge clk);
    @(negedge clk);
    h_wvalid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errs++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    #12;
    // R1: reset state at the ports
    check("R1 arready", h_arready, 1);
    check("R1 awready", h_awready, 1);
    check("R1 wready", h_wready, 1);
    check("R1 rvalid", h_rvalid, 0);
    check("R1 bvalid", h_bvalid, 0);
    check("R1 irq", irq, 0);
    @(negedge clk); rst_n = 1;
    fw_read(8'h00); fw_read(8'h04); fw_read(8'h10);

    fw_write(8'h00, 32'h3);                  // R8 enables
    host_ar(32'h0000_0108);                  // R2
    fw_read(8'h00); fw_read(8'h04);
    fw_write(8'h14, 32'h1);                  // R6 ignored, no write held
    fw_write(8'h04, 32'hFFFF_FFFF);          // R9 ignored
    fw_read(8'h04); fw_read(8'h0C); fw_read(8'h14);
    h_rready = 0;
    fw_write(8'h0C, 32'hCAFE_0001);          // R3
    fw_write(8'h0C, 32'h1111_2222);          // R3 no relaunch while outstanding
    idle(3);
    h_rready = 1; idle(2);
    fw_read(8'h00); fw_read(8'h04);          // R4
    fw_write(8'h0C, 32'hDEAD_BEEF);          // R3 ignored, nothing held

    host_aw(32'h0000_0020);                  // R5 address first
    fw_write(8'h14, 32'h1);                  // R6 ignored, data missing
    fw_read(8'h00);
    host_w(32'h1234_5678);
    fw_read(8'h08); fw_read(8'h10); fw_read(8'h00);
    fw_write(8'h08, 32'h0); fw_write(8'h10, 32'h0); // R9
    fw_read(8'h08); fw_read(8'h10);
    fw_write(8'h14, 32'h0);                  // R6 bit0 clear
    h_bready = 0;
    fw_write(8'h14, 32'h1);
    idle(3);
    h_bready = 1; idle(2);
    fw_read(8'h00);                          // R7

    host_w(32'hA5A5_0F0F);                   // R5 data first
    fw_read(8'h00);
    host_aw(32'h0000_0033);
    fw_read(8'h00); fw_read(8'h08);          // R7 done cleared by capture

    // R and B handshakes in the same cycle
    host_ar(32'h0000_000C);
    h_rready = 0; h_bready = 0;
    fw_write(8'h0C, 32'h0BAD_F00D);
    fw_write(8'h14, 32'h1);
    idle(2);
    h_rready = 1; h_bready = 1; idle(2);
    fw_read(8'h00);

    // firmware control read racing a host AR capture
    fork
      fw_read(8'h00);
      host_ar(32'h0000_0044);
    join
    fw_read(8'h00);
    fw_write(8'h00, 32'h0);                  // R8 disable
    idle(2);
    fw_read(8'h00); fw_read(8'h18); fw_read(8'h1C); fw_read(8'hFC); // R9
    fw_write(8'h0C, 32'h7777_0000);
    idle(3);
    finish_run();
  end
endmodule